// File: doc/BRIEF.md
# Interrupt Source Router

This block sits between the raw interrupt lines of a multiprocessor interrupt controller and its per-processor queues. For every source it keeps a configuration word and a destination word. The configuration word holds a mask bit, an activity bit, a delivery-mode bit, polarity and sense bits, a priority and a vector. The destination word holds one enable bit per processor. From the source lines it derives a pending bit per source, using either level or edge sensing. When a source line changes, or its configuration word is written, the block re-evaluates that source. It then emits a one-cycle deliver strobe, tagged with the source index, to each processor that is to receive the request.

Re-evaluation is serialised by a two-state controller. In `ST_IDLE` the controller waits; the transition *pick* fires when any source has an evaluation request, latches the lowest-numbered such source and moves to `ST_ROUTE`. In `ST_ROUTE` the routing decision is made and registered. The transition *finish* returns to `ST_IDLE` unconditionally. Routing covers three cases:

- The source is sent to the single processor it last served, when that is its only destination.
- In directed mode it is offered to every enabled processor.
- In distributed mode it goes to the next enabled processor after the last one served, round-robin.

Each processor's acceptance inputs (its task priority and its raised-set membership for the source) can refuse the offer, in which case the request is dropped. An acknowledge-side strobe clears a source's activity bit.

Top module: `irq_src_router`

## Requirements
- R1: After reset every configuration word reads 0xA0000000, every destination word reads 0, and no deliver strobe is active.
- R2: A configuration write stores only the bits selected by 0xA0CF00FF: mask bit 31, mode bit 29 (1 = distributed), polarity bit 23, sense bit 22 (1 = level), priority bits 19:16 and vector bits 7:0. Activity bit 30 reads back its current value and is never written by software.
- R3: A destination write keeps bits 31:30 and the low NCPU enable bits (bit c enables processor c); every other bit reads 0.
- R4: A level source's pending bit follows its line, and a falling line clears its activity bit. An edge source becomes pending on a rising line and loses pending only through the clear strobe, which also clears activity.
- R5: No strobe is issued for a source that is not pending, is masked, has priority 0, is already active, or has a zero destination.
- R6: In directed mode (bit 29 = 0) each enabled, accepting processor receives a one-cycle strobe with the source index, all in the same cycle.
- R7: In distributed mode the search starts at the processor after the source's last-served one and wraps around. The first enabled processor found receives the strobe and becomes the new last-served processor. Each source's last-served processor resets to 0.
- R8: When the destination word's enable bits equal exactly the one-hot of the last-served processor, only that processor is offered the source, in either mode.
- R9: A processor refuses a source whose priority is at or below its task priority, or that is already in its raised set. A refused request is dropped and does not set activity.
- R10: An accepted delivery sets the source's activity bit, which blocks further deliveries of that source until cleared.
- R11: Only a change on the source line or a configuration write triggers re-evaluation. A destination write alone never causes a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NSRC | Raw source lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_dst | input | 1 | Write target: 1 destination word, 0 configuration word |
| reg_wr_idx | input | IDXW | Source index for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_dst | input | 1 | Read target: 1 destination word, 0 configuration word |
| reg_rd_idx | input | IDXW | Source index for the read |
| reg_rd_data | output | 32 | Combinational read data |
| cpu_task_pri | input | NCPU*4 | Task priority per processor |
| cpu_raised | input | NCPU*NSRC | Raised-set bit, processor c source s at c*NSRC+s |
| act_clr_en | input | 1 | Activity-clear strobe from acknowledge logic |
| act_clr_idx | input | IDXW | Source to clear |
| deliver_valid | output | NCPU | One-cycle deliver strobe per processor |
| deliver_idx | output | NCPU*IDXW | Source index carried with each strobe |

## Verification
The bench targets the round-robin pointer. A router that restarted its search at processor 0, or that kept one pointer for all sources, would keep hitting the same processor across three successive deliveries. It also targets the refusal paths. A design that compared task priority with greater-or-equal, or that set activity even when every processor refused, would show up as a strobe to the wrong processor, or as a later redelivery being blocked. It checks that clearing activity on an edge source also clears pending, and that a falling level line releases activity. A design that got these wrong would either redeliver a stale edge or lock a level source out for good. Finally, a destination-only write must stay silent, which catches a router that re-evaluates on every register write.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ROUTE = 1'b1
    } rtr_state_e;

    localparam int CFG_MASK_BIT  = 31;
    localparam int CFG_ACT_BIT   = 30;
    localparam int CFG_MODE_BIT  = 29;
    localparam int CFG_SENSE_BIT = 22;
    localparam int CFG_PRI_LO    = 16;
    localparam int PRI_W         = 4;

    localparam logic [31:0] CFG_RESET_WORD = 32'hA000_0000;
    localparam logic [31:0] CFG_WR_MASK    = 32'hA0CF_00FF;
    localparam logic [31:0] DST_HI_KEEP    = 32'hC000_0000;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_rtr_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NCPU = 2,
    parameter int IDXW = 4,
    parameter int CPUW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_in,
    input  logic                  wr_en,
    input  logic                  wr_dst,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [31:0]           wr_data,
    input  logic                  rd_dst,
    input  logic [IDXW-1:0]       rd_idx,
    output logic [31:0]           rd_data,
    input  logic                  clr_en,
    input  logic [IDXW-1:0]       clr_idx,
    input  logic                  set_en,
    input  logic [IDXW-1:0]       set_idx,
    input  logic                  take_en,
    input  logic [IDXW-1:0]       take_idx,
    input  logic                  last_en,
    input  logic [IDXW-1:0]       last_idx,
    input  logic [CPUW-1:0]       last_val,
    output logic [NSRC-1:0]       pend_o,
    output logic [NSRC-1:0]       act_o,
    output logic [NSRC-1:0]       req_o,
    output logic [NSRC-1:0]       mask_o,
    output logic [NSRC-1:0]       mode_o,
    output logic [NSRC*PRI_W-1:0] pri_o,
    output logic [NSRC*NCPU-1:0]  dst_o,
    output logic [NSRC*CPUW-1:0]  last_o
);
    localparam logic [31:0] DST_KEEP = DST_HI_KEEP | ((32'd1 << NCPU) - 32'd1);

    logic [NSRC*32-1:0] cfg_rd_flat;
    logic [NSRC*32-1:0] dst_rd_flat;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [31:0]     cfg_r;
        logic [31:0]     dst_r;
        logic            pend_r;
        logic            act_r;
        logic            req_r;
        logic            line_r;
        logic [CPUW-1:0] last_r;
        logic            hit_cfg, hit_dst, hit_clr, hit_set, hit_take, hit_last;
        logic            rise, fall;

        always_comb begin
            hit_cfg  = wr_en && !wr_dst && (wr_idx == IDXW'(i));
            hit_dst  = wr_en &&  wr_dst && (wr_idx == IDXW'(i));
            hit_clr  = clr_en  && (clr_idx  == IDXW'(i));
            hit_set  = set_en  && (set_idx  == IDXW'(i));
            hit_take = take_en && (take_idx == IDXW'(i));
            hit_last = last_en && (last_idx == IDXW'(i));
            rise     = src_in[i] && !line_r;
            fall     = !src_in[i] && line_r;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r  <= CFG_RESET_WORD;
                dst_r  <= '0;
                pend_r <= 1'b0;
                act_r  <= 1'b0;
                req_r  <= 1'b0;
                line_r <= 1'b0;
                last_r <= '0;
            end else begin
                line_r <= src_in[i];
                if (hit_cfg) cfg_r <= wr_data & CFG_WR_MASK;
                if (hit_dst) dst_r <= wr_data & DST_KEEP;
                if (cfg_r[CFG_SENSE_BIT])  pend_r <= src_in[i];
                else if (rise)             pend_r <= 1'b1;
                else if (hit_clr)          pend_r <= 1'b0;
                if (hit_set)               act_r <= 1'b1;
                else if (hit_clr || (cfg_r[CFG_SENSE_BIT] && fall))
                                           act_r <= 1'b0;
                if (rise || fall || hit_cfg) req_r <= 1'b1;
                else if (hit_take)           req_r <= 1'b0;
                if (hit_last) last_r <= last_val;
            end
        end

        assign cfg_rd_flat[i*32 +: 32]    = cfg_r | (32'(act_r) << CFG_ACT_BIT);
        assign dst_rd_flat[i*32 +: 32]    = dst_r;
        assign pend_o[i]                  = pend_r;
        assign act_o[i]                   = act_r;
        assign req_o[i]                   = req_r;
        assign mask_o[i]                  = cfg_r[CFG_MASK_BIT];
        assign mode_o[i]                  = cfg_r[CFG_MODE_BIT];
        assign pri_o[i*PRI_W +: PRI_W]    = cfg_r[CFG_PRI_LO +: PRI_W];
        assign dst_o[i*NCPU +: NCPU]      = dst_r[NCPU-1:0];
        assign last_o[i*CPUW +: CPUW]     = last_r;
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (rd_idx == IDXW'(s))
                rd_data = rd_dst ? dst_rd_flat[s*32 +: 32] : cfg_rd_flat[s*32 +: 32];
        end
    end
endmodule

// File: rtl/irq_route_calc.sv
module irq_route_calc
    import irq_rtr_pkg::*;
#(
    parameter int NCPU = 2,
    parameter int CPUW = 1
) (
    input  logic                  pend,
    input  logic                  masked,
    input  logic                  active,
    input  logic                  dist_mode,
    input  logic [PRI_W-1:0]      pri,
    input  logic [NCPU-1:0]       dst_en,
    input  logic [CPUW-1:0]       last,
    input  logic [NCPU*PRI_W-1:0] task_pri,
    input  logic [NCPU-1:0]       raised,
    output logic [NCPU-1:0]       dlv,
    output logic                  directed,
    output logic                  upd_last,
    output logic [CPUW-1:0]       new_last
);
    logic            gate;
    logic [NCPU-1:0] accept;
    logic [NCPU-1:0] last_hot;
    logic            found;
    logic [CPUW-1:0] rr_pick;

    always_comb begin
        gate = pend && !masked && (pri != '0) && !active && (dst_en != '0);
        for (int c = 0; c < NCPU; c++)
            accept[c] = (pri > task_pri[c*PRI_W +: PRI_W]) && !raised[c];
        last_hot = NCPU'(1) << last;
        found    = 1'b0;
        rr_pick  = '0;
        for (int k = 1; k < NCPU; k++) begin
            if (!found && dst_en[(int'(last) + k) % NCPU]) begin
                found   = 1'b1;
                rr_pick = CPUW'((int'(last) + k) % NCPU);
            end
        end
    end

    always_comb begin
        dlv      = '0;
        directed = 1'b0;
        upd_last = 1'b0;
        new_last = last;
        if (gate) begin
            if (dst_en == last_hot) begin
                dlv = last_hot & accept;
            end else if (!dist_mode) begin
                dlv      = dst_en & accept;
                directed = 1'b1;
            end else if (found) begin
                dlv      = (NCPU'(1) << rr_pick) & accept;
                upd_last = 1'b1;
                new_last = rr_pick;
            end
        end
    end
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_rtr_pkg::*;
#(
    parameter  int NSRC = 16,
    parameter  int NCPU = 2,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       irq_line,
    input  logic                  reg_wr_en,
    input  logic                  reg_wr_dst,
    input  logic [IDXW-1:0]       reg_wr_idx,
    input  logic [31:0]           reg_wr_data,
    input  logic                  reg_rd_dst,
    input  logic [IDXW-1:0]       reg_rd_idx,
    output logic [31:0]           reg_rd_data,
    input  logic [NCPU*PRI_W-1:0] cpu_task_pri,
    input  logic [NCPU*NSRC-1:0]  cpu_raised,
    input  logic                  act_clr_en,
    input  logic [IDXW-1:0]       act_clr_idx,
    output logic [NCPU-1:0]       deliver_valid,
    output logic [NCPU*IDXW-1:0]  deliver_idx
);
    rtr_state_e          state_q, state_d;
    logic [IDXW-1:0]     sel_q;
    logic [IDXW-1:0]     pick_idx;
    logic [NSRC-1:0]     pend_vec, act_vec, req_vec, mask_vec, mode_vec;
    logic [NSRC*PRI_W-1:0] pri_flat;
    logic [NSRC*NCPU-1:0]  dst_flat;
    logic [NSRC*CPUW-1:0]  last_flat;
    logic [NCPU-1:0]     raised_row;
    logic [NCPU-1:0]     route_dlv;
    logic                route_dir, route_upd;
    logic [CPUW-1:0]     route_last;
    logic                take_en, set_en, last_en;
    logic [IDXW-1:0]     dlv_src_q;
    logic                dlv_dir_q;

    always_comb begin
        pick_idx = '0;
        for (int s = NSRC - 1; s >= 0; s--)
            if (req_vec[s]) pick_idx = IDXW'(s);
        for (int c = 0; c < NCPU; c++)
            raised_row[c] = cpu_raised[c*NSRC + int'(sel_q)];
        take_en = (state_q == ST_IDLE) && (req_vec != '0);
        set_en  = (state_q == ST_ROUTE) && (route_dlv != '0);
        last_en = (state_q == ST_ROUTE) && route_upd;
    end

    irq_src_bank #(.NSRC(NSRC), .NCPU(NCPU), .IDXW(IDXW), .CPUW(CPUW)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_in(irq_line),
        .wr_en(reg_wr_en), .wr_dst(reg_wr_dst), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
        .rd_dst(reg_rd_dst), .rd_idx(reg_rd_idx), .rd_data(reg_rd_data),
        .clr_en(act_clr_en), .clr_idx(act_clr_idx),
        .set_en(set_en), .set_idx(sel_q),
        .take_en(take_en), .take_idx(pick_idx),
        .last_en(last_en), .last_idx(sel_q), .last_val(route_last),
        .pend_o(pend_vec), .act_o(act_vec), .req_o(req_vec), .mask_o(mask_vec),
        .mode_o(mode_vec), .pri_o(pri_flat), .dst_o(dst_flat), .last_o(last_flat)
    );

    irq_route_calc #(.NCPU(NCPU), .CPUW(CPUW)) u_route (
        .pend(pend_vec[sel_q]), .masked(mask_vec[sel_q]), .active(act_vec[sel_q]),
        .dist_mode(mode_vec[sel_q]),
        .pri(pri_flat[int'(sel_q)*PRI_W +: PRI_W]),
        .dst_en(dst_flat[int'(sel_q)*NCPU +: NCPU]),
        .last(last_flat[int'(sel_q)*CPUW +: CPUW]),
        .task_pri(cpu_task_pri), .raised(raised_row),
        .dlv(route_dlv), .directed(route_dir), .upd_last(route_upd), .new_last(route_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_vec != '0) state_d = ST_ROUTE;
            ST_ROUTE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_en) sel_q <= pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_valid <= '0;
            dlv_src_q     <= '0;
            dlv_dir_q     <= 1'b0;
        end else begin
            deliver_valid <= (state_q == ST_ROUTE) ? route_dlv : '0;
            dlv_src_q     <= sel_q;
            dlv_dir_q     <= route_dir;
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_out
        assign deliver_idx[c*IDXW +: IDXW] = deliver_valid[c] ? dlv_src_q : '0;
    end
endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk
    import irq_rtr_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int NCPU = 2,
    parameter int IDXW = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCPU-1:0]       deliver_valid,
    input logic [IDXW-1:0]       sel_q,
    input logic                  dlv_dir_q,
    input logic [NSRC-1:0]       act_vec,
    input logic [NSRC-1:0]       pend_vec,
    input logic [NSRC-1:0]       mask_vec,
    input logic [NSRC*PRI_W-1:0] pri_flat,
    input logic [NSRC*NCPU-1:0]  dst_flat,
    input logic [NCPU*PRI_W-1:0] cpu_task_pri
);
    AST_ACT_AFTER_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid != '0) |-> act_vec[sel_q]); // R10

    AST_GATED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid != '0) |-> $past(pend_vec[sel_q] && !mask_vec[sel_q]
            && (pri_flat[int'(sel_q)*PRI_W +: PRI_W] != '0)
            && (dst_flat[int'(sel_q)*NCPU +: NCPU] != '0))); // R5

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_valid != '0) |=> (deliver_valid == '0)); // R6

    AST_ROUND_ROBIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((deliver_valid != '0) && !dlv_dir_q) |-> $onehot(deliver_valid)); // R7

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        AST_ABOVE_TASK_PRI: assert property (@(posedge clk) disable iff (!rst_n)
            deliver_valid[c] |-> $past(pri_flat[int'(sel_q)*PRI_W +: PRI_W]
                > cpu_task_pri[c*PRI_W +: PRI_W])); // R9
    end
endmodule

bind irq_src_router irq_src_router_chk #(.NSRC(NSRC), .NCPU(NCPU), .IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .deliver_valid(deliver_valid), .sel_q(sel_q),
    .dlv_dir_q(dlv_dir_q), .act_vec(act_vec), .pend_vec(pend_vec), .mask_vec(mask_vec),
    .pri_flat(pri_flat), .dst_flat(dst_flat), .cpu_task_pri(cpu_task_pri)
);

// File: tb/irq_src_router_bench.sv
module irq_src_router_bench;
    localparam int NSRC = 16;
    localparam int NCPU = 2;
    localparam int IW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_line = '0;
    logic              reg_wr_en = 1'b0, reg_wr_dst = 1'b0;
    logic [IW-1:0]     reg_wr_idx = '0;
    logic [31:0]       reg_wr_data = '0;
    logic              reg_rd_dst = 1'b0;
    logic [IW-1:0]     reg_rd_idx = '0;
    logic [31:0]       reg_rd_data;
    logic [NCPU*4-1:0] cpu_task_pri = '0;
    logic [NCPU*NSRC-1:0] cpu_raised = '0;
    logic              act_clr_en = 1'b0;
    logic [IW-1:0]     act_clr_idx = '0;
    logic [NCPU-1:0]   deliver_valid;
    logic [NCPU*IW-1:0] deliver_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_src_router #(.NSRC(NSRC), .NCPU(NCPU)) u_irq_src_router (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .reg_wr_en(reg_wr_en), .reg_wr_dst(reg_wr_dst), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .reg_rd_dst(reg_rd_dst), .reg_rd_idx(reg_rd_idx),
        .reg_rd_data(reg_rd_data), .cpu_task_pri(cpu_task_pri), .cpu_raised(cpu_raised),
        .act_clr_en(act_clr_en), .act_clr_idx(act_clr_idx),
        .deliver_valid(deliver_valid), .deliver_idx(deliver_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input bit dst, input int idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_dst = dst; reg_wr_idx = IW'(idx); reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input bit dst, input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd_dst = dst; reg_rd_idx = IW'(idx);
        #1;
        check(req, reg_rd_data, exp);
    endtask

    task automatic line(input int idx, input bit v);
        @(negedge clk);
        irq_line[idx] = v;
    endtask

    task automatic ack(input int idx);
        @(negedge clk);
        act_clr_en = 1'b1; act_clr_idx = IW'(idx);
        @(negedge clk);
        act_clr_en = 1'b0;
    endtask

    task automatic expect_dlv(input logic [NCPU-1:0] exp_mask, input int exp_idx, input string req);
        logic [NCPU-1:0] seen = '0;
        logic            idx_ok = 1'b1;
        repeat (6) begin
            @(negedge clk);
            for (int c = 0; c < NCPU; c++)
                if (deliver_valid[c]) begin
                    seen[c] = 1'b1;
                    if (deliver_idx[c*IW +: IW] != IW'(exp_idx)) idx_ok = 1'b0;
                end
        end
        check({req, " mask"}, 32'(seen), 32'(exp_mask));
        if (exp_mask != '0) check({req, " idx"}, 32'(idx_ok), 32'd1);
    endtask

    task automatic t_reset;
        rd_chk(1'b0, 3, 32'hA000_0000, "R1 cfg reset");
        rd_chk(1'b1, 3, 32'h0, "R1 dst reset");
        check("R1 no strobe", 32'(deliver_valid), 32'h0);
    endtask

    task automatic t_fields;
        wr(1'b0, 1, 32'hFFFF_FFFF);
        expect_dlv('0, 0, "R5 masked write");
        rd_chk(1'b0, 1, 32'hA0CF_00FF, "R2 cfg mask");
        wr(1'b1, 1, 32'hFFFF_FFFF);
        rd_chk(1'b1, 1, 32'hC000_0003, "R3 dst mask");
    endtask

    task automatic t_directed;
        wr(1'b0, 2, 32'h0005_0042);
        wr(1'b1, 2, 32'h3);
        expect_dlv('0, 0, "R4 not pending");
        line(2, 1'b1);
        expect_dlv(2'b11, 2, "R6 directed");
        rd_chk(1'b0, 2, 32'h4005_0042, "R10 activity set");
        line(2, 1'b0); line(2, 1'b1);
        expect_dlv('0, 0, "R10 active blocks");
        ack(2);
        rd_chk(1'b0, 2, 32'h0005_0042, "R4 clear activity");
        wr(1'b0, 2, 32'h0005_0042);
        expect_dlv('0, 0, "R4 edge pending cleared");
        line(2, 1'b0);
        expect_dlv('0, 0, "R4 edge fall");
    endtask

    task automatic t_level;
        wr(1'b0, 3, 32'h0046_0033);
        wr(1'b1, 3, 32'h1);
        line(3, 1'b1);
        expect_dlv(2'b01, 3, "R8 level one-hot last");
        line(3, 1'b0);
        expect_dlv('0, 0, "R4 level fall");
        rd_chk(1'b0, 3, 32'h0046_0033, "R4 level fall clears act");
    endtask

    task automatic t_gating;
        wr(1'b0, 4, 32'h0000_0044); wr(1'b1, 4, 32'h3);
        line(4, 1'b1);
        expect_dlv('0, 0, "R5 priority zero");
        wr(1'b0, 5, 32'h8005_0055); wr(1'b1, 5, 32'h3);
        line(5, 1'b1);
        expect_dlv('0, 0, "R5 masked");
        wr(1'b0, 6, 32'h0005_0066);
        line(6, 1'b1);
        expect_dlv('0, 0, "R5 no destination");
        wr(1'b1, 6, 32'h1);
        expect_dlv('0, 0, "R11 dst write silent");
        wr(1'b0, 6, 32'h0005_0066);
        expect_dlv(2'b01, 6, "R11 cfg write re-evaluates");
        ack(4); ack(5); ack(6);
        line(4, 1'b0); line(5, 1'b0); line(6, 1'b0);
        expect_dlv('0, 0, "R5 cleanup");
    endtask

    task automatic t_accept;
        wr(1'b0, 7, 32'h0003_0077); wr(1'b1, 7, 32'h3);
        cpu_task_pri = {4'd2, 4'd3};
        line(7, 1'b1);
        expect_dlv(2'b10, 7, "R9 task priority at-or-below");
        ack(7); line(7, 1'b0);
        expect_dlv('0, 0, "R9 idle");
        cpu_task_pri = '0;
        cpu_raised[1*NSRC + 7] = 1'b1;
        line(7, 1'b1);
        expect_dlv(2'b01, 7, "R9 raised refuses");
        ack(7); line(7, 1'b0);
        cpu_raised = '0;
        cpu_task_pri = {4'd15, 4'd15};
        line(7, 1'b1);
        expect_dlv('0, 0, "R9 all refuse");
        rd_chk(1'b0, 7, 32'h0003_0077, "R9 drop leaves act clear");
        ack(7); line(7, 1'b0);
        cpu_task_pri = '0;
        expect_dlv('0, 0, "R9 cleanup");
    endtask

    task automatic t_distributed;
        wr(1'b0, 8, 32'h2005_0088); wr(1'b1, 8, 32'h3);
        line(8, 1'b1);
        expect_dlv(2'b10, 8, "R7 first after last");
        ack(8); line(8, 1'b0); line(8, 1'b1);
        expect_dlv(2'b01, 8, "R7 wrap");
        ack(8); line(8, 1'b0); line(8, 1'b1);
        expect_dlv(2'b10, 8, "R7 rotate again");
        ack(8); line(8, 1'b0);
        wr(1'b1, 8, 32'h2);
        line(8, 1'b1);
        expect_dlv(2'b10, 8, "R8 one-hot last distributed");
        ack(8); line(8, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_directed();
        t_level();
        t_gating();
        t_accept();
        t_distributed();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule